// File: doc/BRIEF.md
# Saturating Doubling Multiply-High Vector Unit

This block is a lane-parallel signed integer datapath. It accepts two packed source vectors and splits them into 16-bit or 32-bit lanes. Each lane multiplies its pair of two's-complement operands at full precision and doubles the product. An optional rounding constant is added, and the lane keeps the upper element-width bits of the result. If that value does not fit the signed range of the lane, it is clamped. Every clamped lane sets a bit in a per-lane summary and raises a sticky cumulative flag. Software clears that flag with a dedicated pulse.

The operand stream is valid/ready on both sides. A transfer happens on a rising edge where valid and ready are both high. `in_ready` equals `!out_valid || out_ready`, so the block holds exactly one result and accepts a new operation in the same cycle that the held result leaves. While `out_valid` is high and `out_ready` is low, the result and its side outputs stay frozen and no input is taken.

The control fields travel with the operands. These are the element-size code, the 64/128-bit width select, the scalar/vector mode and the rounding enable. A size code that names neither 16-bit nor 32-bit lanes is reported as an undefined encoding and produces no data.

Top module: `dbl_mulhi_unit`

## Requirements
- R1: Size codes 2'b00 and 2'b11 are undefined. The registered output then has `out_undef`=1, `out_data`=0 and `out_lane_sat`=0, and `sat_sticky` is not set by that operation.
- R2: Size code 2'b01 selects 16-bit lanes, with lane i at bits [16i+15:16i]. With rounding off, each lane is (2·a·b) >>> 16, where a and b are signed.
- R3: Size code 2'b10 selects 32-bit lanes, with lane i at bits [32i+31:32i]. With rounding off, each lane is (2·a·b) >>> 32, where a and b are signed.
- R4: With `round_en`=1, 2^(EW−1) is added to the doubled product before the arithmetic shift by EW, where EW is the element width.
- R5: A lane clamps only when both operands are the most negative value. It then returns the most positive value (0x7FFF or 0x7FFFFFFF) and sets bit i of `out_lane_sat`.
- R6: In vector mode, `wide_sel`=0 makes the low 64 bits active and `wide_sel`=1 makes all 128 bits active. Result bits and summary bits of inactive lanes are 0, and those lanes never clamp or set the flag.
- R7: In scalar mode (`scalar_mode`=1), only lane 0 of the selected width is computed. Every other result bit and summary bit is 0.
- R8: `sat_sticky` becomes 1 on the accepting edge of an operation with any active lane clamped. It stays 1 until cleared. If a clear and a clamp fall on the same edge, the set wins.
- R9: `sat_clr`=1 clears `sat_sticky` on the next rising edge.
- R10: A result appears with `out_valid`=1 one edge after acceptance. `in_ready` equals `!out_valid || out_ready`, and the outputs stay stable while they are stalled.
- R11: After reset, `out_valid`=0 and `sat_sticky`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken |
| op_a | input | 128 | First source vector |
| op_b | input | 128 | Second source vector |
| size_code | input | 2 | Element size: 01=16-bit, 10=32-bit, others undefined |
| wide_sel | input | 1 | 0 = 64-bit vector, 1 = 128-bit vector |
| scalar_mode | input | 1 | 1 = single element in lane 0 |
| round_en | input | 1 | Add rounding constant before the shift |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Packed lane results |
| out_lane_sat | output | 8 | Per-lane clamp summary (bit i = lane i) |
| out_undef | output | 1 | Operation used an undefined size code |
| sat_clr | input | 1 | Synchronous clear of the sticky flag |
| sat_sticky | output | 1 | Cumulative clamp flag |

## Verification
Clamping happens only for one operand pair per lane width. The stimulus therefore places most-negative values in both operands deliberately. It does this in active lanes, in lanes that a 64-bit or scalar operation leaves inactive, and under undefined size codes. That shows the flag is raised only when an active lane clamps. The set-versus-clear race on the sticky flag needs a clear pulse on the exact edge that accepts a clamping operation, which a directed test arranges. Back-pressure is reached by holding `out_ready` low while a second operation waits at the input.

// File: rtl/dmh_pkg.sv
package dmh_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } elem_size_e;

  // number of lanes that carry data for a given bank
  function automatic int active_lanes(input int bank_lanes, input logic wide,
                                      input logic scalar);
    if (scalar)    return 1;
    else if (wide) return bank_lanes;
    else           return bank_lanes / 2;
  endfunction

endpackage

// File: rtl/dmh_lane.sv
module dmh_lane #(
  parameter int EW = 16
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic          round_en,
  output logic [EW-1:0] res,
  output logic          sat
);
  localparam int PW = 2*EW + 2;
  localparam logic signed [PW-1:0] MAXP = (PW'(1) <<< (EW-1)) - PW'(1);
  localparam logic signed [PW-1:0] MINP = -(PW'(1) <<< (EW-1));
  localparam logic [EW-1:0] MAXE = {1'b0, {(EW-1){1'b1}}};
  localparam logic [EW-1:0] MINE = {1'b1, {(EW-1){1'b0}}};

  logic signed [PW-1:0] ea, eb, prod, biased, shifted;

  always_comb begin
    ea      = {{(PW-EW){a[EW-1]}}, a};
    eb      = {{(PW-EW){b[EW-1]}}, b};
    prod    = (ea * eb) <<< 1;
    biased  = prod + (round_en ? (PW'(1) <<< (EW-1)) : PW'(0));
    shifted = biased >>> EW;
    sat     = (shifted > MAXP) || (shifted < MINP);
    if (sat) res = shifted[PW-1] ? MINE : MAXE;
    else     res = shifted[EW-1:0];
  end

  // R5: clamping only arises from most-negative times most-negative
  always_comb begin
    if (sat) begin
      a_r5_only_min_pair: assert (a == MINE && b == MINE && res == MAXE);
    end
  end

endmodule

// File: rtl/dmh_lane_bank.sv
module dmh_lane_bank #(
  parameter int EW    = 16,
  parameter int MAX_W = 128
) (
  input  logic [MAX_W-1:0]           a,
  input  logic [MAX_W-1:0]           b,
  input  logic                       round_en,
  input  logic [$clog2(MAX_W/EW+1)-1:0] n_active,
  output logic [MAX_W-1:0]           res,
  output logic [MAX_W/EW-1:0]        sat
);
  localparam int NL = MAX_W / EW;
  localparam int CW = $clog2(NL+1);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [EW-1:0] lr;
    logic          ls;
    logic          keep;
    dmh_lane #(.EW(EW)) u_lane (
      .a        (a[i*EW +: EW]),
      .b        (b[i*EW +: EW]),
      .round_en (round_en),
      .res      (lr),
      .sat      (ls)
    );
    assign keep             = (CW'(i) < n_active);
    assign res[i*EW +: EW]  = keep ? lr : '0;
    assign sat[i]           = keep & ls;
  end

endmodule

// File: rtl/dbl_mulhi_unit.sv
module dbl_mulhi_unit #(
  parameter int MAX_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [MAX_W-1:0]   op_a,
  input  logic [MAX_W-1:0]   op_b,
  input  logic [1:0]         size_code,
  input  logic               wide_sel,
  input  logic               scalar_mode,
  input  logic               round_en,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [MAX_W-1:0]   out_data,
  output logic [MAX_W/16-1:0] out_lane_sat,
  output logic               out_undef,
  input  logic               sat_clr,
  output logic               sat_sticky
);
  import dmh_pkg::*;

  localparam int EW_H = 16;
  localparam int EW_S = 32;
  localparam int NL_H = MAX_W / EW_H;
  localparam int NL_S = MAX_W / EW_S;
  localparam int CW_H = $clog2(NL_H+1);
  localparam int CW_S = $clog2(NL_S+1);

  logic [CW_H-1:0]  n_h;
  logic [CW_S-1:0]  n_s;
  logic [MAX_W-1:0] res_h, res_s, res_sel;
  logic [NL_H-1:0]  sat_h, sat_sel;
  logic [NL_S-1:0]  sat_s;
  logic             undef, accept;
  elem_size_e       sz;

  assign sz  = elem_size_e'(size_code);
  assign n_h = CW_H'(active_lanes(NL_H, wide_sel, scalar_mode));
  assign n_s = CW_S'(active_lanes(NL_S, wide_sel, scalar_mode));

  dmh_lane_bank #(.EW(EW_H), .MAX_W(MAX_W)) u_bank_h (
    .a(op_a), .b(op_b), .round_en(round_en), .n_active(n_h),
    .res(res_h), .sat(sat_h)
  );

  dmh_lane_bank #(.EW(EW_S), .MAX_W(MAX_W)) u_bank_s (
    .a(op_a), .b(op_b), .round_en(round_en), .n_active(n_s),
    .res(res_s), .sat(sat_s)
  );

  always_comb begin
    undef   = 1'b0;
    res_sel = '0;
    sat_sel = '0;
    unique case (sz)
      SZ_HALF: begin res_sel = res_h; sat_sel = sat_h; end
      SZ_WORD: begin res_sel = res_s; sat_sel = NL_H'(sat_s); end
      default: undef = 1'b1;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_lane_sat <= '0;
      out_undef    <= 1'b0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_data     <= res_sel;
      out_lane_sat <= sat_sel;
      out_undef    <= undef;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    sat_sticky <= 1'b0;
    else if (accept && |sat_sel)   sat_sticky <= 1'b1;
    else if (sat_clr)              sat_sticky <= 1'b0;
  end

  // R1: undefined encodings carry no data and no clamp bits
  a_r1_undef_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_undef) |-> (out_data == '0 && out_lane_sat == '0));

  // R8: the flag only falls after a clear request
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sat_sticky) |-> $past(sat_clr));

  // R8: a freshly accepted clamping result always leaves the flag set
  a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready) && |out_lane_sat) |-> sat_sticky);

  // R10: stalled output holds
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                  && $stable(out_lane_sat) && $stable(out_undef)));

  // R10: no acceptance while stalled
  a_r10_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7: scalar mode leaves only lane 0 in the summary
  a_r7_scalar_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && scalar_mode) |=> (out_lane_sat[NL_H-1:1] == '0));

endmodule

// File: tb/tb_dbl_mulhi_unit.sv
module tb_dbl_mulhi_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] op_a = '0, op_b = '0;
  logic [1:0]   size_code = 2'b01;
  logic         wide_sel = 1'b0, scalar_mode = 1'b0, round_en = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic [7:0]   out_lane_sat;
  logic         out_undef;
  logic         sat_clr = 1'b0;
  logic         sat_sticky;

  int checks = 0;
  int failures = 0;
  logic exp_sticky = 1'b0;

  always #10 clk = ~clk;

  dbl_mulhi_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .size_code(size_code), .wide_sel(wide_sel),
    .scalar_mode(scalar_mode), .round_en(round_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_lane_sat(out_lane_sat),
    .out_undef(out_undef), .sat_clr(sat_clr), .sat_sticky(sat_sticky)
  );

  localparam int NV = 8;
  localparam logic [127:0] TA [NV] = '{
    128'h8000_0000_8000_0000_8000_0000_8000_0000,
    128'h8000_8000_8000_8000_8000_8000_8000_8000,
    128'h8000_7FFF_1234_FEDC_0001_C000_4000_FFFF,
    128'h8000_7FFF_1234_FEDC_0001_C000_4000_FFFF,
    128'h8000_0000_7FFF_FFFF_1234_5678_FFFF_FFFE,
    128'h8000_0000_8000_0000_0000_1000_FFFF_F001,
    128'h8000_0000_8000_0000_8000_0000_0001_0000,
    128'h8000_8000_8000_8000_8000_8000_8000_8000
  };
  localparam logic [127:0] TB [NV] = '{
    128'h8000_0000_8000_0000_8000_0000_8000_0000,
    128'h8000_8000_8000_8000_8000_8000_8000_8000,
    128'h7FFF_7FFF_5678_0123_FFFF_C000_4000_8000,
    128'h7FFF_7FFF_5678_0123_FFFF_C000_4000_8000,
    128'h7FFF_FFFF_7FFF_FFFF_9ABC_DEF0_0000_0003,
    128'h8000_0000_8000_0000_0003_0000_0000_7FFF,
    128'h8000_0000_8000_0000_8000_0000_0001_0000,
    128'h8000_8000_8000_8000_8000_8000_8000_8000
  };
  localparam logic [1:0] TSZ [NV] = '{2'b00, 2'b11, 2'b01, 2'b01, 2'b10, 2'b10, 2'b10, 2'b01};
  localparam logic TWD [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic TSC [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic TRN [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

  // Independent reference computed from the requirement text
  function automatic void model(input logic [127:0] a, input logic [127:0] b,
                                input logic [1:0] sz, input logic wd,
                                input logic sc, input logic rn,
                                output logic [127:0] d, output logic [7:0] s,
                                output logic u);
    int ew, nl;
    d = '0; s = '0; u = 1'b0;
    if (sz == 2'b01) ew = 16;
    else if (sz == 2'b10) ew = 32;
    else begin u = 1'b1; return; end
    nl = sc ? 1 : (wd ? 128/ew : 64/ew);
    for (int i = 0; i < nl; i++) begin
      longint ea, eb, p, mx, mn;
      logic [31:0] ua, ub;
      ua = 32'(a >> (i*ew));
      ub = 32'(b >> (i*ew));
      if (ew == 16) begin
        ea = longint'($signed(ua[15:0])); eb = longint'($signed(ub[15:0]));
      end else begin
        ea = longint'($signed(ua)); eb = longint'($signed(ub));
      end
      mx = (longint'(1) <<< (ew-1)) - 1;
      mn = -(longint'(1) <<< (ew-1));
      if (ea == mn && eb == mn) begin
        p = mx; s[i] = 1'b1;
      end else begin
        p = 2 * ea * eb;
        if (rn) p = p + (longint'(1) <<< (ew-1));
        p = p >>> ew;
      end
      if (ew == 16) d[i*16 +: 16] = 16'(p);
      else          d[i*32 +: 32] = 32'(p);
    end
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [127:0] a, input logic [127:0] b,
                       input logic [1:0] sz, input logic wd, input logic sc,
                       input logic rn);
    @(negedge clk);
    op_a = a; op_b = b; size_code = sz; wide_sel = wd;
    scalar_mode = sc; round_en = rn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_and_check(input logic [127:0] a, input logic [127:0] b,
                               input logic [1:0] sz, input logic wd,
                               input logic sc, input logic rn, input string tag);
    logic [127:0] ed; logic [7:0] es; logic eu;
    model(a, b, sz, wd, sc, rn, ed, es, eu);
    issue(a, b, sz, wd, sc, rn);
    if (|es) exp_sticky = 1'b1;
    chk(out_valid == 1'b1, {tag, " R10 valid"}, 128'(out_valid), 128'(1));
    chk(out_data == ed, {tag, " data"}, out_data, ed);
    chk(out_lane_sat == es, {tag, " R5 lane_sat"}, 128'(out_lane_sat), 128'(es));
    chk(out_undef == eu, {tag, " R1 undef"}, 128'(out_undef), 128'(eu));
    chk(sat_sticky == exp_sticky, {tag, " R8 sticky"}, 128'(sat_sticky), 128'(exp_sticky));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] d1, d2; logic [7:0] s1; logic u1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11 out_valid", 128'(out_valid), 128'(0));
    chk(sat_sticky == 1'b0, "R11 sticky", 128'(sat_sticky), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready idle", 128'(in_ready), 128'(1));

    // Table: R1 undef codes, R2/R3 lane math, R4 rounding, R6 width, R7 scalar, R5 clamp
    for (int k = 0; k < NV; k++) begin
      run_and_check(TA[k], TB[k], TSZ[k], TWD[k], TSC[k], TRN[k],
                    $sformatf("vec%0d R2 R3 R4 R6 R7", k));
    end

    // R9: clear takes effect on the next edge
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0; exp_sticky = 1'b0;
    chk(sat_sticky == 1'b0, "R9 clear", 128'(sat_sticky), 128'(0));

    // R6: clamp candidates only in inactive upper lanes of a 64-bit op
    run_and_check({64'h8000_8000_8000_8000, 64'h0001_0002_0003_0004},
                  {64'h8000_8000_8000_8000, 64'h7FFF_7FFF_7FFF_7FFF},
                  2'b01, 1'b0, 1'b0, 1'b0, "R6 inactive lanes");

    // R8: set wins against a simultaneous clear
    @(negedge clk);
    op_a = {8{16'h8000}}; op_b = {8{16'h8000}}; size_code = 2'b01;
    wide_sel = 1'b1; scalar_mode = 1'b0; round_en = 1'b0;
    in_valid = 1'b1; sat_clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
    chk(sat_sticky == 1'b1, "R8 set beats clear", 128'(sat_sticky), 128'(1));
    chk(out_lane_sat == 8'hFF, "R5 all lanes clamp", 128'(out_lane_sat), 128'(8'hFF));
    chk(out_data == {8{16'h7FFF}}, "R5 clamp value", out_data, {8{16'h7FFF}});
    // R8: flag stays set across idle cycles
    repeat (3) @(negedge clk);
    chk(sat_sticky == 1'b1, "R8 hold", 128'(sat_sticky), 128'(1));

    // R10: back-pressure
    model(128'h0004_0003, 128'h4000_4000, 2'b01, 1'b1, 1'b0, 1'b0, d1, s1, u1);
    model(128'h0100_0200, 128'h0300_0400, 2'b01, 1'b1, 1'b0, 1'b0, d2, s1, u1);
    @(negedge clk);
    out_ready = 1'b0;
    op_a = 128'h0004_0003; op_b = 128'h4000_4000; in_valid = 1'b1;
    @(negedge clk);
    op_a = 128'h0100_0200; op_b = 128'h0300_0400;
    chk(in_ready == 1'b0, "R10 not ready while stalled", 128'(in_ready), 128'(0));
    @(negedge clk);
    chk(out_data == d1, "R10 held data", out_data, d1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_data == d2, "R10 second after release", out_data, d2);
    chk(out_valid == 1'b1, "R10 valid after release", 128'(out_valid), 128'(1));
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 drained", 128'(out_valid), 128'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule